// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving half of an inter-processor mailbox. Remote cores deliver messages through a push port. Each message carries a 64-bit payload, split into a low and a high 32-bit word, and a source channel number. The messages are held in a circular queue of `DEPTH` entries. A local host reaches the queue through a small register window with separate write and read address ports. Reads are combinational and return the oldest entry; nothing is consumed by reading it. The host then writes a pop command to discard that entry and bring up the next.

The occupancy is not reported as a count. The status register exposes the raw write and read pointers, plus a full flag that tells a full queue from an empty one when the two pointers are equal. Software computes the fill level as (write − read) modulo `DEPTH`. A sticky "message arrived" status bit feeds a maskable interrupt line.

The asynchronous reset input is synchronised inside the block before it is used.

Top module: `mbx_outbox_rx`

## Requirements
- R1: Two clock cycles after `rst_n` is released, the block is in its reset state: both pointers 0, full flag 0, arrival status 0, interrupt mask 5'h1F, `irq` low.
- R2: Address 0x14 reads the queue state. Bit 0 is the full flag, bits [23:16] are the write pointer, bits [31:24] are the read pointer, and all other bits read 0.
- R3: An accepted push stores the message at the write pointer and advances the write pointer by one, wrapping from `DEPTH`−1 to 0. If the write pointer then equals the read pointer, the full flag is set.
- R4: When the queue is not empty, the oldest entry reads at 0x04 (low word), 0x08 (high word) and 0x00 (channel number, zero-extended). Reading has no side effect.
- R5: A write to 0x0C with bit 0 set pops the oldest entry. The read pointer advances modulo `DEPTH` and the full flag clears. A write to 0x0C with bit 0 clear does nothing.
- R6: A push while the queue is full is dropped. Pointers, flag and stored entries stay unchanged.
- R7: A pop command while the queue is empty has no effect.
- R8: A push and a pop in the same cycle both take effect, and the full flag keeps its value. When the queue is full in that cycle, only the pop takes effect.
- R9: Writing the value 0 to 0x10 empties the queue: both pointers go to 0 and the full flag clears. This write takes priority over a push or pop in the same cycle. Any nonzero write to 0x10 is ignored.
- R10: Address 0x24 reads `DEPTH`−1.
- R11: Bit 0 at 0x18 is the arrival status. It is set by every accepted push and cleared by writing 1 to bit 0 of 0x18. When a push and a clear happen in the same cycle, the set wins.
- R12: Address 0x1C holds a 5-bit mask in bits [4:0], readable and writable. A set bit disables its source. `irq` is high exactly when the arrival status is 1 and mask bit 0 is 0.
- R13: Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | Remote message delivery strobe |
| push_lo | input | 32 | Payload low word |
| push_hi | input | 32 | Payload high word |
| push_id | input | ID_W | Source channel number |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Message-arrival interrupt |

## Verification
Every push, pop, clear or register write takes effect at the single rising edge where it is presented. Its result is visible on `rd_data` and `irq` right after that edge, because reads are combinational from registers. The bench drives each stimulus for exactly one cycle, starting at a falling edge. It then samples at the following falling edges, one read address per low phase, and compares against a model advanced by the same single-cycle rule. The reset state is checked only after the two-stage reset synchroniser has released.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int PTR_W  = 8;
  localparam int MASK_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CHAN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LO    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_HI    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_POP   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_ISTS  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IMSK  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DEPTH = 6'h24;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mbx_ptr_ctrl.sv
module mbx_ptr_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_req,
  input  logic                      pop_req,
  input  logic                      clr,
  output logic [mbx_pkg::PTR_W-1:0] wptr,
  output logic [mbx_pkg::PTR_W-1:0] rptr,
  output logic                      full,
  output logic                      push_acc,
  output logic                      pop_acc
);
  import mbx_pkg::*;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic             full_q, full_d, empty;
  logic             wptr_en, rptr_en, full_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = !full_q && (wptr_q == rptr_q);
    push_acc = push_req && !full_q && !clr;
    pop_acc  = pop_req && !empty && !clr;
    wptr_en  = push_acc || clr;
    rptr_en  = pop_acc || clr;
    full_en  = clr || (push_acc != pop_acc);
    wptr_d   = clr ? '0 : bump(wptr_q);
    rptr_d   = clr ? '0 : bump(rptr_q);
    if (clr)           full_d = 1'b0;
    else if (push_acc) full_d = (bump(wptr_q) == rptr_q);
    else               full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wptr_en) wptr_q <= wptr_d;
      if (rptr_en) rptr_q <= rptr_d;
      if (full_en) full_q <= full_d;
    end
  end

  assign wptr = wptr_q;
  assign rptr = rptr_q;
  assign full = full_q;
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [mbx_pkg::DATA_W-1:0] wlo,
  input  logic [mbx_pkg::DATA_W-1:0] whi,
  input  logic [ID_W-1:0]            wid,
  input  logic [IDX_W-1:0]           raddr,
  output logic [mbx_pkg::DATA_W-1:0] rlo,
  output logic [mbx_pkg::DATA_W-1:0] rhi,
  output logic [ID_W-1:0]            rid
);
  import mbx_pkg::*;

  logic [DATA_W-1:0] lo_q [DEPTH];
  logic [DATA_W-1:0] hi_q [DEPTH];
  logic [ID_W-1:0]   id_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (ent_en) begin
        lo_q[i] <= wlo;
        hi_q[i] <= whi;
        id_q[i] <= wid;
      end
    end
  end

  assign rlo = lo_q[raddr];
  assign rhi = hi_q[raddr];
  assign rid = id_q[raddr];
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [mbx_pkg::ADDR_W-1:0] wr_addr,
  input  logic [mbx_pkg::DATA_W-1:0] wr_data,
  input  logic [mbx_pkg::ADDR_W-1:0] rd_addr,
  input  logic                       push_acc,
  input  logic [mbx_pkg::PTR_W-1:0]  wptr,
  input  logic [mbx_pkg::PTR_W-1:0]  rptr,
  input  logic                       full,
  input  logic [mbx_pkg::DATA_W-1:0] head_lo,
  input  logic [mbx_pkg::DATA_W-1:0] head_hi,
  input  logic [ID_W-1:0]            head_id,
  output logic                       pop_req,
  output logic                       clr,
  output logic                       irq_sts,
  output logic [mbx_pkg::MASK_W-1:0] irq_mask,
  output logic [mbx_pkg::DATA_W-1:0] rd_data,
  output logic                       irq
);
  import mbx_pkg::*;

  logic              sts_q, sts_d, sts_en;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              mask_en, sts_w1c;

  always_comb begin
    pop_req = wr_en && (wr_addr == OFS_POP) && wr_data[0];
    clr     = wr_en && (wr_addr == OFS_CLR) && (wr_data == '0);
    sts_w1c = wr_en && (wr_addr == OFS_ISTS) && wr_data[0];
    sts_en  = push_acc || sts_w1c;
    sts_d   = push_acc;
    mask_en = wr_en && (wr_addr == OFS_IMSK);
    mask_d  = wr_data[MASK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      if (sts_en)  sts_q  <= sts_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CHAN:  rd_data = DATA_W'(head_id);
      OFS_LO:    rd_data = head_lo;
      OFS_HI:    rd_data = head_hi;
      OFS_STAT:  rd_data = {rptr, wptr, 15'b0, full};
      OFS_ISTS:  rd_data = DATA_W'(sts_q);
      OFS_IMSK:  rd_data = DATA_W'(mask_q);
      OFS_DEPTH: rd_data = DATA_W'(DEPTH - 1);
      default:   rd_data = '0;
    endcase
  end

  assign irq      = sts_q && !mask_q[0];
  assign irq_sts  = sts_q;
  assign irq_mask = mask_q;
endmodule

// File: rtl/mbx_outbox_rx.sv
module mbx_outbox_rx #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_vld,
  input  logic [31:0] push_lo,
  input  logic [31:0] push_hi,
  input  logic [ID_W-1:0] push_id,
  input  logic        wr_en,
  input  logic [5:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [5:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  import mbx_pkg::*;
  localparam int IDX_W = $clog2(DEPTH);

  logic             rst_sync_n;
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, push_acc, pop_acc, pop_req, clr;
  logic             irq_sts;
  logic [MASK_W-1:0] irq_mask;
  logic [DATA_W-1:0] head_lo, head_hi;
  logic [ID_W-1:0]   head_id;

  mbx_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbx_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push_req (push_vld),
    .pop_req  (pop_req),
    .clr      (clr),
    .wptr     (wptr),
    .rptr     (rptr),
    .full     (full),
    .push_acc (push_acc),
    .pop_acc  (pop_acc)
  );

  mbx_store #(.DEPTH(DEPTH), .ID_W(ID_W), .IDX_W(IDX_W)) i_store (
    .clk   (clk),
    .we    (push_acc),
    .waddr (wptr[IDX_W-1:0]),
    .wlo   (push_lo),
    .whi   (push_hi),
    .wid   (push_id),
    .raddr (rptr[IDX_W-1:0]),
    .rlo   (head_lo),
    .rhi   (head_hi),
    .rid   (head_id)
  );

  mbx_regs #(.DEPTH(DEPTH), .ID_W(ID_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .push_acc (push_acc),
    .wptr     (wptr),
    .rptr     (rptr),
    .full     (full),
    .head_lo  (head_lo),
    .head_hi  (head_hi),
    .head_id  (head_id),
    .pop_req  (pop_req),
    .clr      (clr),
    .irq_sts  (irq_sts),
    .irq_mask (irq_mask),
    .rd_data  (rd_data),
    .irq      (irq)
  );
endmodule

// File: rtl/mbx_outbox_rx_chk.sv
module mbx_outbox_rx_chk #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       push_vld,
  input logic       pop_req,
  input logic       pop_acc,
  input logic       clr,
  input logic       push_acc,
  input logic [7:0] wptr,
  input logic [7:0] rptr,
  input logic       full,
  input logic       irq_sts,
  input logic [4:0] irq_mask,
  input logic       irq
);
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wptr) < DEPTH) && (32'(rptr) < DEPTH)); // R3

  AST_FULL_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wptr == rptr)); // R2

  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_vld && !pop_req && !clr) |=> ($stable(wptr) && $stable(rptr) && full)); // R6

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && (wptr == rptr) && pop_req && !push_vld && !clr) |=> ($stable(rptr) && $stable(wptr))); // R7

  AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !push_acc && !clr) |=> !full); // R5

  AST_ARRIVAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> irq_sts); // R11

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full && (wptr == 8'd0) && (rptr == 8'd0))); // R9

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask[0] |-> !irq); // R12
endmodule

bind mbx_outbox_rx mbx_outbox_rx_chk #(.DEPTH(DEPTH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .push_vld (push_vld),
  .pop_req  (pop_req),
  .pop_acc  (pop_acc),
  .clr      (clr),
  .push_acc (push_acc),
  .wptr     (wptr),
  .rptr     (rptr),
  .full     (full),
  .irq_sts  (irq_sts),
  .irq_mask (irq_mask),
  .irq      (irq)
);

// File: tb/test_mbx_outbox_rx.sv
`timescale 1ns/100ps
module test_mbx_outbox_rx;
  localparam int D = 4;

  logic        clk, rst_n;
  logic        push_vld, wr_en;
  logic [31:0] push_lo, push_hi, wr_data, rd_data;
  logic [2:0]  push_id;
  logic [5:0]  wr_addr, rd_addr;
  logic        irq;

  int total, bad;
  logic [31:0] m_lo [256];
  logic [31:0] m_hi [256];
  logic [2:0]  m_id [256];
  int   m_w, m_r;
  logic m_full, m_sts;
  logic [4:0] m_mask;

  mbx_outbox_rx #(.DEPTH(D), .ID_W(3)) i_mbx_outbox_rx (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_lo(push_lo),
    .push_hi(push_hi), .push_id(push_id), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic step(input bit dp, input logic [31:0] lo, input logic [31:0] hi,
                      input logic [2:0] id, input bit dw, input logic [5:0] a,
                      input logic [31:0] d);
    bit empty, clr, push_ok, pop_ok;
    @(negedge clk);
    push_vld = dp; push_lo = lo; push_hi = hi; push_id = id;
    wr_en = dw; wr_addr = a; wr_data = d;
    empty   = (m_w == m_r) && !m_full;
    clr     = dw && (a == 6'h10) && (d == 32'd0);
    push_ok = dp && !m_full && !clr;
    pop_ok  = dw && (a == 6'h0C) && d[0] && !empty && !clr;
    @(negedge clk);
    push_vld = 1'b0; wr_en = 1'b0;
    if (clr) begin
      m_w = 0; m_r = 0; m_full = 1'b0;
    end else begin
      if (push_ok) begin
        m_lo[m_w] = lo; m_hi[m_w] = hi; m_id[m_w] = id;
        m_w = (m_w + 1) % D;
      end
      if (pop_ok) m_r = (m_r + 1) % D;
      if (push_ok && !pop_ok && m_w == m_r) m_full = 1'b1;
      if (pop_ok && !push_ok) m_full = 1'b0;
    end
    if (push_ok) m_sts = 1'b1;
    else if (dw && a == 6'h18 && d[0]) m_sts = 1'b0;
    if (dw && a == 6'h1C) m_mask = d[4:0];
  endtask

  task automatic push(input int n);
    step(1'b1, 32'hA500_0000 + 32'(n * 37), ~(32'h0101_0000 * 32'(n)), 3'(n), 1'b0, 6'h00, 32'd0);
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    step(1'b0, 32'd0, 32'd0, 3'd0, 1'b1, a, d);
  endtask

  task automatic look(input string req);
    logic [31:0] v;
    rd(6'h14, v);
    chk({req, " R2 status"}, v, {8'(m_r), 8'(m_w), 15'd0, m_full});
    if (m_full || m_w != m_r) begin
      rd(6'h04, v); chk({req, " R4 low"}, v, m_lo[m_r]);
      rd(6'h08, v); chk({req, " R4 high"}, v, m_hi[m_r]);
      rd(6'h00, v); chk({req, " R4 chan"}, v, 32'(m_id[m_r]));
    end
    rd(6'h18, v); chk({req, " R11 arrival"}, v, 32'(m_sts));
    chk({req, " R12 irq"}, 32'(irq), 32'(m_sts && !m_mask[0]));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    total = 0; bad = 0;
    m_w = 0; m_r = 0; m_full = 0; m_sts = 0; m_mask = 5'h1F;
    push_vld = 0; push_lo = 0; push_hi = 0; push_id = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(6'h14, v); chk("R1 status", v, 32'd0);
    rd(6'h18, v); chk("R1 arrival", v, 32'd0);
    rd(6'h1C, v); chk("R1 mask", v, 32'h1F);
    chk("R1 irq", 32'(irq), 32'd0);
    // R10 depth, R13 unmapped
    rd(6'h24, v); chk("R10 depth", v, 32'(D - 1));
    for (int a = 0; a < 64; a += 4) begin
      if (!(a inside {0, 4, 8, 20, 24, 28, 36})) begin
        rd(6'(a), v); chk("R13 unmapped", v, 32'd0);
      end
    end

    // R7 pop while empty
    wreg(6'h0C, 32'd1); look("R7 empty pop");

    // R3 fill, R6 overfill
    for (int i = 0; i < D; i++) begin push(i); look("R3 fill"); end
    chk("R3 full flag", 32'(m_full), 32'd1);
    push(99); look("R6 drop when full");

    // R5 drain, and ignored pop with bit0 clear
    wreg(6'h0C, 32'hFFFF_FFFE); look("R5 pop bit0 clear");
    for (int i = 0; i < D; i++) begin wreg(6'h0C, 32'd1); look("R5 drain"); end

    // R3/R5/R8 wrap sweep with mixed operations
    for (int s = 0; s < 48; s++) begin
      int op;
      op = (s * 7 + s / 5) % 5;
      if (op < 2)       push(s + 10);
      else if (op == 2) wreg(6'h0C, 32'd1);
      else if (op == 3) step(1'b1, 32'h5A5A_0000 + 32'(s), 32'(s * 3), 3'(s + 1), 1'b1, 6'h0C, 32'd1);
      else              wreg(6'h08, 32'd0);
      look("R8 sweep");
    end

    // R8 push and pop with queue full
    while (!m_full) push(50);
    step(1'b1, 32'hDEAD_0001, 32'hDEAD_0002, 3'd7, 1'b1, 6'h0C, 32'd1);
    look("R8 full push+pop");

    // R9 nonzero ignored, zero clears
    wreg(6'h10, 32'd4); look("R9 nonzero clear ignored");
    wreg(6'h10, 32'd0); look("R9 clear");
    rd(6'h14, v); chk("R9 status zero", v, 32'd0);

    // R11 / R12 interrupt
    wreg(6'h18, 32'd1); look("R11 w1c");
    wreg(6'h1C, 32'hFFFF_FFE0); rd(6'h1C, v); chk("R12 mask width", v, 32'd0);
    wreg(6'h1C, 32'h1E); rd(6'h1C, v); chk("R12 mask rw", v, 32'h1E);
    look("R12 unmasked idle");
    push(3); look("R12 irq rises");
    wreg(6'h1C, 32'h1F); look("R12 masked");
    wreg(6'h1C, 32'h00);
    step(1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 3'd5, 1'b1, 6'h18, 32'd1);
    look("R11 set wins");
    wreg(6'h18, 32'd0); look("R11 write zero");
    wreg(6'h18, 32'd1); look("R11 cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule